// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home directory for a small shared-memory system. It keeps a coherence state and a per-node presence vector for every block it owns. Nodes send read, write and eviction requests on a valid/ready channel. The controller answers most requests at once. When other nodes hold the block, it sends them invalidations or a forward/downgrade. It waits for an acknowledgement from each of them and then grants the requester.

Only one transaction is open at any time. A request for the block under transaction gets a negative acknowledgement (NACK) and must be retried, because nothing is queued. A request for any other block is stalled by holding `req_ready` low. Data movement, the network and memory timing are not modelled. Only directory state and message order are.

The controller FSM has two states. `CS_IDLE` decides each request in the cycle it is accepted. On a request that needs messages it takes the *issue* transition to `CS_COLLECT`. `CS_COLLECT` gathers acknowledgements, answers requests for the busy block with NACK (the *reject* self-loop), and takes the *complete* transition back to `CS_IDLE` on the last expected acknowledgement. Each block is in one of three directory states: `ST_U` (uncached), `ST_S` (shared) or `ST_EM` (exclusive/modified, owned).

Top module: `dir_home_ctrl`

## Requirements
- R1: Directory states are encoded U=2'b00, S=2'b01, EM=2'b10. After reset every block is U with an empty presence vector. In EM exactly one presence bit is set, and in U none is set.
- R2: A read or write (req_op 2'b00 read, 2'b01 write) to a U block makes it EM, with the requester as the only holder. The response is GRANT_EX (rsp_kind 2'b01).
- R3: A read of an EM block by a node that is not the owner sends one FWD message (msg_kind 1) with only the owner's bit set in msg_mask. After the owner acknowledges, the requester gets GRANT_SH (rsp_kind 2'b00) and the block becomes S, held by both nodes.
- R4: A write to an S block that has sharers other than the requester sends INV (msg_kind 0) to all of those sharers and not to the requester. GRANT_EX follows only after every one of them has acknowledged, and the requester is then the sole owner.
- R5: A write to an EM block by a node that is not the owner sends INV to the owner. After the owner acknowledges, the requester gets GRANT_EX and becomes the owner.
- R6: These requests are answered at once with no message:
  - a read of an S block gets GRANT_SH and adds the requester as a sharer;
  - any request from the owner of an EM block gets GRANT_EX;
  - a write to an S block whose only sharer is the requester gets GRANT_EX and makes the block EM.
- R7: An eviction (req_op[1]=1) removes the requester's presence bit and returns EVICT_DONE (rsp_kind 2'b11). When no bit remains, the block becomes U. An eviction by a node that holds nothing changes nothing.
- R8: While a transaction is open, a request for the same block is accepted and answered with NACK (rsp_kind 2'b10). It leaves the directory and the open transaction unchanged.
- R9: While a transaction is open, a request for any other block is not accepted (req_ready low).
- R10: An acknowledgement from a node that was not sent a message, or that has already acknowledged, is ignored. The grant is issued only in the cycle after the last expected acknowledgement.
- R11: A response (rsp_valid) or a message (msg_valid) appears exactly one cycle after the request is accepted. A message lasts one cycle, and a message and a response never appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Target block |
| req_op | input | 2 | 00 read, 01 write, 1x evict |
| ack_valid | input | 1 | Node acknowledgement present |
| ack_node | input | $clog2(NODES) | Acknowledging node |
| msg_valid | output | 1 | Coherence message to nodes |
| msg_blk | output | $clog2(BLOCKS) | Block the message concerns |
| msg_mask | output | NODES | Destination nodes |
| msg_kind | output | 1 | 0 INV, 1 FWD |
| rsp_valid | output | 1 | Response to a requester |
| rsp_node | output | $clog2(NODES) | Node receiving the response |
| rsp_blk | output | $clog2(BLOCKS) | Block of the response |
| rsp_kind | output | 2 | 00 GRANT_SH, 01 GRANT_EX, 10 NACK, 11 EVICT_DONE |

## Verification
A wrong directory entry does not show at the ports when it is written. It shows on the next request to that block: an unexpected msg_mask, a missing or extra message, or the wrong grant kind. The bench therefore keeps a model of every block, checks each response against it, and revisits blocks often in random traffic. A wrong acknowledgement count or a lost busy flag shows within a cycle as an early grant, a missing NACK, or req_ready high for another block.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        ST_U  = 2'b00,
        ST_S  = 2'b01,
        ST_EM = 2'b10
    } dir_state_e;

    typedef enum logic [1:0] {
        RSP_GRANT_SH   = 2'b00,
        RSP_GRANT_EX   = 2'b01,
        RSP_NACK       = 2'b10,
        RSP_EVICT_DONE = 2'b11
    } rsp_kind_e;

    localparam logic MSG_INV = 1'b0;
    localparam logic MSG_FWD = 1'b1;

    typedef enum logic {
        CS_IDLE    = 1'b0,
        CS_COLLECT = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/dir_store.sv
module dir_store
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] rd_blk,
    output dir_state_e                rd_state,
    output logic [NODES-1:0]          rd_pres,
    input  logic                      wr_en,
    input  logic [$clog2(BLOCKS)-1:0] wr_blk,
    input  dir_state_e                wr_state,
    input  logic [NODES-1:0]          wr_pres
);
    localparam int BW = $clog2(BLOCKS);

    dir_state_e       st_q [BLOCKS];
    logic [NODES-1:0] pr_q [BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) begin
                st_q[i] <= ST_U;
                pr_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < BLOCKS; i++) begin
                if (wr_blk == BW'(i)) begin
                    st_q[i] <= wr_state;
                    pr_q[i] <= wr_pres;
                end
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_pres  = pr_q[rd_blk];

endmodule

// File: rtl/dir_policy.sv
module dir_policy
    import dir_pkg::*;
#(
    parameter int NODES = 4
) (
    input  dir_state_e                cur_state,
    input  logic [NODES-1:0]          cur_pres,
    input  logic [$clog2(NODES)-1:0]  req_node,
    input  logic [1:0]                req_op,
    output logic                      upd,
    output dir_state_e                new_state,
    output logic [NODES-1:0]          new_pres,
    output rsp_kind_e                 imm_kind,
    output logic                      need_msg,
    output logic                      msg_kind,
    output logic [NODES-1:0]          msg_mask,
    output dir_state_e                fin_state,
    output logic [NODES-1:0]          fin_pres,
    output rsp_kind_e                 fin_kind
);
    logic [NODES-1:0] req_bit;
    logic [NODES-1:0] others;
    logic             is_evict;
    logic             is_write;

    assign req_bit  = NODES'(1) << req_node;
    assign others   = cur_pres & ~req_bit;
    assign is_evict = req_op[1];
    assign is_write = (req_op == 2'b01);

    always_comb begin
        upd       = 1'b0;
        new_state = cur_state;
        new_pres  = cur_pres;
        imm_kind  = RSP_GRANT_EX;
        need_msg  = 1'b0;
        msg_kind  = MSG_INV;
        msg_mask  = '0;
        fin_state = ST_EM;
        fin_pres  = req_bit;
        fin_kind  = RSP_GRANT_EX;
        if (is_evict) begin
            imm_kind = RSP_EVICT_DONE;
            if ((cur_pres & req_bit) != '0) begin
                upd       = 1'b1;
                new_pres  = others;
                new_state = (others == '0) ? ST_U : cur_state;
            end
        end else begin
            unique case (cur_state)
                ST_U: begin
                    upd       = 1'b1;
                    new_state = ST_EM;
                    new_pres  = req_bit;
                    imm_kind  = RSP_GRANT_EX;
                end
                ST_S: begin
                    if (!is_write) begin
                        upd      = 1'b1;
                        new_pres = cur_pres | req_bit;
                        imm_kind = RSP_GRANT_SH;
                    end else if (others == '0) begin
                        upd       = 1'b1;
                        new_state = ST_EM;
                        new_pres  = req_bit;
                        imm_kind  = RSP_GRANT_EX;
                    end else begin
                        need_msg = 1'b1;
                        msg_kind = MSG_INV;
                        msg_mask = others;
                    end
                end
                ST_EM: begin
                    if (others == '0) begin
                        imm_kind = RSP_GRANT_EX;
                    end else if (!is_write) begin
                        need_msg  = 1'b1;
                        msg_kind  = MSG_FWD;
                        msg_mask  = others;
                        fin_state = ST_S;
                        fin_pres  = cur_pres | req_bit;
                        fin_kind  = RSP_GRANT_SH;
                    end else begin
                        need_msg = 1'b1;
                        msg_kind = MSG_INV;
                        msg_mask = others;
                    end
                end
                default: begin
                    upd       = 1'b1;
                    new_state = ST_EM;
                    new_pres  = req_bit;
                end
            endcase
        end
    end

endmodule

// File: rtl/ack_collector.sv
module ack_collector #(
    parameter int NODES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NODES-1:0]         load_mask,
    input  logic                     ack_valid,
    input  logic [$clog2(NODES)-1:0] ack_node,
    output logic                     done
);
    logic [NODES-1:0] pending_q;
    logic [NODES-1:0] ack_bit;
    logic             hit;

    assign ack_bit = NODES'(1) << ack_node;
    assign hit     = ack_valid && ((pending_q & ack_bit) != '0);
    assign done    = hit && ((pending_q & ~ack_bit) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (load) begin
            pending_q <= load_mask;
        end else if (hit) begin
            pending_q <= pending_q & ~ack_bit;
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [$clog2(NODES)-1:0]  req_node,
    input  logic [$clog2(BLOCKS)-1:0] req_blk,
    input  logic [1:0]                req_op,
    input  logic                      ack_valid,
    input  logic [$clog2(NODES)-1:0]  ack_node,
    output logic                      msg_valid,
    output logic [$clog2(BLOCKS)-1:0] msg_blk,
    output logic [NODES-1:0]          msg_mask,
    output logic                      msg_kind,
    output logic                      rsp_valid,
    output logic [$clog2(NODES)-1:0]  rsp_node,
    output logic [$clog2(BLOCKS)-1:0] rsp_blk,
    output logic [1:0]                rsp_kind
);
    localparam int NW = $clog2(NODES);
    localparam int BW = $clog2(BLOCKS);

    ctrl_state_e      cs_q, cs_d;
    logic [BW-1:0]    busy_blk_q;
    logic [NW-1:0]    owner_req_q;
    dir_state_e       fin_state_q;
    logic [NODES-1:0] fin_pres_q;
    rsp_kind_e        fin_kind_q;

    dir_state_e       rd_state;
    logic [NODES-1:0] rd_pres;
    logic             upd;
    dir_state_e       new_state;
    logic [NODES-1:0] new_pres;
    rsp_kind_e        imm_kind;
    logic             need_msg;
    logic             p_msg_kind;
    logic [NODES-1:0] p_msg_mask;
    dir_state_e       p_fin_state;
    logic [NODES-1:0] p_fin_pres;
    rsp_kind_e        p_fin_kind;
    logic             done;

    logic             busy;
    logic             req_fire;
    logic             issue;
    logic             wr_en;
    logic [BW-1:0]    wr_blk;
    dir_state_e       wr_state;
    logic [NODES-1:0] wr_pres;

    assign busy      = (cs_q == CS_COLLECT);
    assign req_ready = !busy || ((req_blk == busy_blk_q) && !done);
    assign req_fire  = req_valid && req_ready;
    assign issue     = !busy && req_fire && need_msg;

    dir_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_blk   (req_blk),
        .rd_state (rd_state),
        .rd_pres  (rd_pres),
        .wr_en    (wr_en),
        .wr_blk   (wr_blk),
        .wr_state (wr_state),
        .wr_pres  (wr_pres)
    );

    dir_policy #(.NODES(NODES)) u_policy (
        .cur_state (rd_state),
        .cur_pres  (rd_pres),
        .req_node  (req_node),
        .req_op    (req_op),
        .upd       (upd),
        .new_state (new_state),
        .new_pres  (new_pres),
        .imm_kind  (imm_kind),
        .need_msg  (need_msg),
        .msg_kind  (p_msg_kind),
        .msg_mask  (p_msg_mask),
        .fin_state (p_fin_state),
        .fin_pres  (p_fin_pres),
        .fin_kind  (p_fin_kind)
    );

    ack_collector #(.NODES(NODES)) u_acks (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (issue),
        .load_mask (p_msg_mask),
        .ack_valid (ack_valid && busy),
        .ack_node  (ack_node),
        .done      (done)
    );

    // Directory write port: immediate update in idle, final update on completion.
    always_comb begin
        if (busy) begin
            wr_en    = done;
            wr_blk   = busy_blk_q;
            wr_state = fin_state_q;
            wr_pres  = fin_pres_q;
        end else begin
            wr_en    = req_fire && upd;
            wr_blk   = req_blk;
            wr_state = new_state;
            wr_pres  = new_pres;
        end
    end

    // Next-state logic.
    always_comb begin
        cs_d = cs_q;
        unique case (cs_q)
            CS_IDLE:    if (issue) cs_d = CS_COLLECT;
            CS_COLLECT: if (done)  cs_d = CS_IDLE;
            default:    cs_d = CS_IDLE;
        endcase
    end

    // State register and transaction context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q        <= CS_IDLE;
            busy_blk_q  <= '0;
            owner_req_q <= '0;
            fin_state_q <= ST_U;
            fin_pres_q  <= '0;
            fin_kind_q  <= RSP_GRANT_EX;
        end else begin
            cs_q <= cs_d;
            if (issue) begin
                busy_blk_q  <= req_blk;
                owner_req_q <= req_node;
                fin_state_q <= p_fin_state;
                fin_pres_q  <= p_fin_pres;
                fin_kind_q  <= p_fin_kind;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_blk   <= '0;
            msg_mask  <= '0;
            msg_kind  <= MSG_INV;
            rsp_valid <= 1'b0;
            rsp_node  <= '0;
            rsp_blk   <= '0;
            rsp_kind  <= 2'b00;
        end else begin
            msg_valid <= issue;
            rsp_valid <= 1'b0;
            if (issue) begin
                msg_blk  <= req_blk;
                msg_mask <= p_msg_mask;
                msg_kind <= p_msg_kind;
            end
            unique case (cs_q)
                CS_IDLE: begin
                    if (req_fire && !need_msg) begin
                        rsp_valid <= 1'b1;
                        rsp_node  <= req_node;
                        rsp_blk   <= req_blk;
                        rsp_kind  <= imm_kind;
                    end
                end
                CS_COLLECT: begin
                    if (done) begin
                        rsp_valid <= 1'b1;
                        rsp_node  <= owner_req_q;
                        rsp_blk   <= busy_blk_q;
                        rsp_kind  <= fin_kind_q;
                    end else if (req_fire) begin
                        rsp_valid <= 1'b1;
                        rsp_node  <= req_node;
                        rsp_blk   <= req_blk;
                        rsp_kind  <= RSP_NACK;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dir_home_sva.sv
module dir_home_sva #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic [$clog2(BLOCKS)-1:0] req_blk,
    input logic                      msg_valid,
    input logic [NODES-1:0]          msg_mask,
    input logic                      msg_kind,
    input logic                      rsp_valid,
    input logic [1:0]                rsp_kind,
    input logic                      busy,
    input logic [$clog2(BLOCKS)-1:0] busy_blk,
    input logic [1:0]                rd_state,
    input logic [NODES-1:0]          rd_pres
);

    a_r11_msg_rsp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !rsp_valid);

    a_r11_msg_single: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    a_r9_other_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && (req_blk != busy_blk)) |-> !req_ready);

    a_r8_nack_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_kind == 2'b10)) |-> $past(busy));

    a_r3_fwd_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind) |-> ($countones(msg_mask) == 1));

    a_r4_msg_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_mask != '0));

    a_r1_em_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == 2'b10) |-> ($countones(rd_pres) == 1));

    a_r1_u_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == 2'b00) |-> (rd_pres == '0));

    a_r11_msg_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> busy);

endmodule

bind dir_home_ctrl dir_home_sva #(.NODES(NODES), .BLOCKS(BLOCKS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_blk   (req_blk),
    .msg_valid (msg_valid),
    .msg_mask  (msg_mask),
    .msg_kind  (msg_kind),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .busy      (busy),
    .busy_blk  (busy_blk_q),
    .rd_state  (rd_state),
    .rd_pres   (rd_pres)
);

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/1ps
module tb_dir_home_ctrl;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int NW = $clog2(NODES);
    localparam int BW = $clog2(BLOCKS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_blk = '0;
    logic [1:0] req_op = 2'b00;
    logic ack_valid = 1'b0;
    logic [NW-1:0] ack_node = '0;
    logic msg_valid;
    logic [BW-1:0] msg_blk;
    logic [NODES-1:0] msg_mask;
    logic msg_kind;
    logic rsp_valid;
    logic [NW-1:0] rsp_node;
    logic [BW-1:0] rsp_blk;
    logic [1:0] rsp_kind;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Model: 0 U, 1 S, 2 EM
    int m_st [BLOCKS];
    logic [NODES-1:0] m_pr [BLOCKS];

    always #2.5 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int pick_bit(input logic [NODES-1:0] m);
        int j;
        j = $urandom % NODES;
        while (!m[j]) j = (j + 1) % NODES;
        return j;
    endfunction

    task automatic probe_nack(input int b);
        int n;
        n = $urandom % NODES;
        req_valid = 1; req_node = NW'(n); req_blk = BW'(b); req_op = 2'($urandom % 3);
        #1 check(req_ready == 1, "R8 busy-block request accepted", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        check(rsp_valid == 1 && rsp_kind == 2'b10, "R8 NACK kind", rsp_kind, 2);
        check(rsp_node == NW'(n), "R8 NACK node", rsp_node, n);
    endtask

    task automatic probe_other(input int b);
        req_valid = 1; req_node = '0; req_blk = BW'((b + 1) % BLOCKS); req_op = 2'b00;
        #1 check(req_ready == 0, "R9 other block stalled", req_ready, 0);
        req_valid = 0;
    endtask

    task automatic do_req(input int n, input int b, input int op);
        logic [NODES-1:0] rb, p, others, mm;
        int s, kind, fs, mk;
        logic [NODES-1:0] fp;
        bit msg;
        rb = NODES'(1) << n;
        s = m_st[b]; p = m_pr[b]; others = p & ~rb;
        msg = 0; mm = '0; mk = 0; kind = 1; fs = 2; fp = rb;
        if (op == 2) begin
            kind = 3;
            if ((p & rb) != 0) begin
                fp = others; fs = (others == 0) ? 0 : s;
            end else begin
                fp = p; fs = s;
            end
        end else if (s == 0) begin
            kind = 1; fs = 2; fp = rb;
        end else if (s == 1) begin
            if (op == 0) begin kind = 0; fs = 1; fp = p | rb; end
            else if (others == 0) begin kind = 1; fs = 2; fp = rb; end
            else begin msg = 1; mk = 0; mm = others; kind = 1; fs = 2; fp = rb; end
        end else begin
            if (others == 0) begin kind = 1; fs = 2; fp = p; end
            else if (op == 0) begin msg = 1; mk = 1; mm = others; kind = 0; fs = 1; fp = p | rb; end
            else begin msg = 1; mk = 0; mm = others; kind = 1; fs = 2; fp = rb; end
        end

        @(negedge clk);
        req_valid = 1; req_node = NW'(n); req_blk = BW'(b); req_op = 2'(op);
        #1 check(req_ready == 1, "R9 idle accepts", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        if (!msg) begin
            check(rsp_valid == 1 && msg_valid == 0, "R11 immediate response", rsp_valid, 1);
            check(rsp_kind == 2'(kind), (op == 2) ? "R7 evict response" :
                  (s == 0) ? "R2 uncached grant" : "R6 immediate grant kind", rsp_kind, kind);
            check(rsp_node == NW'(n) && rsp_blk == BW'(b), "R11 response addressing", rsp_node, n);
        end else begin
            check(msg_valid == 1 && rsp_valid == 0, "R11 message one cycle after accept", msg_valid, 1);
            check(msg_mask == mm, (mk == 1) ? "R3 FWD mask" : (s == 1) ? "R4 INV mask" : "R5 INV mask",
                  msg_mask, mm);
            check(msg_kind == mk && msg_blk == BW'(b), "R3 message kind", msg_kind, mk);
            if ($urandom % 2) probe_nack(b);
            probe_other(b);
            begin
                int j;
                j = pick_bit(~(mm));
                ack_valid = 1; ack_node = NW'(j);
                @(posedge clk); @(negedge clk);
                ack_valid = 0;
                check(rsp_valid == 0, "R10 stray ack ignored", rsp_valid, 0);
            end
            begin
                logic [NODES-1:0] pend;
                pend = mm;
                while (pend != 0) begin
                    int i;
                    i = pick_bit(pend);
                    ack_valid = 1; ack_node = NW'(i);
                    @(posedge clk); @(negedge clk);
                    ack_valid = 0;
                    pend[i] = 1'b0;
                    if (pend != 0) begin
                        check(rsp_valid == 0, "R10 no grant before last ack", rsp_valid, 0);
                        ack_valid = 1; ack_node = NW'(i);
                        @(posedge clk); @(negedge clk);
                        ack_valid = 0;
                        check(rsp_valid == 0, "R10 repeated ack ignored", rsp_valid, 0);
                    end else begin
                        check(rsp_valid == 1 && rsp_kind == 2'(kind),
                              (mk == 1) ? "R3 GRANT_SH after fwd ack" : "R4 R5 GRANT_EX after acks",
                              rsp_kind, kind);
                        check(rsp_node == NW'(n) && rsp_blk == BW'(b), "R10 grant addressing", rsp_node, n);
                    end
                end
            end
        end
        m_st[b] = fs; m_pr[b] = fp;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired, all requirements");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < BLOCKS; i++) begin m_st[i] = 0; m_pr[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 0 && msg_valid == 0, "R1 reset outputs idle", rsp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R1 ready after reset", req_ready, 1);

        // Directed corner cases.
        do_req(0, 1, 0);   // R2 U -> EM
        do_req(0, 1, 1);   // R6 owner write
        do_req(1, 1, 0);   // R3 forward to owner
        do_req(2, 1, 0);   // R6 shared read
        do_req(2, 1, 1);   // R4 invalidate sharers 0,1
        do_req(3, 1, 1);   // R5 invalidate owner
        do_req(0, 1, 2);   // R7 evict by non-holder
        do_req(3, 1, 2);   // R7 owner evict -> U
        do_req(1, 1, 1);   // R1 U again, R2 write grant
        do_req(0, 2, 0);
        do_req(1, 2, 0);   // S {0,1}
        do_req(0, 2, 2);   // R7 one sharer leaves
        do_req(1, 2, 1);   // R6 lone sharer write -> EM
        do_req(1, 2, 2);   // R7 back to U
        do_req(2, 2, 0);   // R2

        // Random traffic over few blocks to revisit state.
        for (int k = 0; k < 400; k++) begin
            do_req($urandom % NODES, $urandom % 3, $urandom % 3);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule